// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple single-request host port and an external asynchronous static RAM of 512K words by 16 bits. The host presents a 19-bit word address, a read/write flag, 16 bits of write data and two active-low byte-lane enables, and raises `req_valid` for one cycle while the controller is idle. The controller then runs one complete memory cycle. It drives the memory's active-low chip select, write enable, output enable and the two byte strobes. It controls the enable of the data pads and returns read data together with a one-cycle `done` pulse.

Every memory timing minimum is a nanosecond parameter. Each is turned into a clock-cycle count by taking the ceiling of the minimum divided by the clock period. Write enable is the signal that ends a write, and output enable never goes low during one. After each read there is a quiet window so that the memory releases the bus before the controller can drive it again. When the controller is idle it holds the memory in standby. All memory control lines come straight from flip-flops.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and while idle, `mem_cs_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all 1, `mem_dq_drive` is 0, and `busy` and `done` are 0.
- R2: An accepted write pulls chip select, write enable and the enabled strobes low in the same cycle and holds them low for the write window. The window is the largest of the write-pulse, select-to-end, address-to-end and data-overlap cycle counts: 15 cycles with the defaults at a 4 ns clock. The data pads are driven with the write data from the first low cycle until one cycle after write enable rises. Output enable stays 1 throughout.
- R3: Byte-enable bit 0 (active low) controls the lower strobe, which covers data bits 7:0. Bit 1 controls the upper strobe, which covers bits 15:8. A write stores only the lanes whose strobe is low.
- R4: An accepted read holds chip select, output enable and the enabled strobes low for the read window: 18 cycles by default. During the read, write enable stays 1 and the pads are not driven. The data bus is sampled on the last cycle of the window.
- R5: In the returned `rdata`, any lane whose byte enable was 1 reads as zero. Enabled lanes carry the memory contents.
- R6: After a read, all memory controls are 1 and the pads are undriven for the turnaround count (5 cycles by default) before `done`. The pads are never driven while output enable is low, nor within the turnaround count after it rises.
- R7: `busy` is 1 from the cycle after acceptance until `done`. `done` lasts exactly one cycle, and `busy` is 0 whenever `done` is 1. `req_valid` is ignored while busy. Done arrives 17 cycles after the accepting edge for a write and 24 cycles for a read.
- R8: A request with both byte enables at 1 produces `done` in the cycle after acceptance and never activates the memory. For a read, `rdata` returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be_n | input | 2 | Active-low byte enables, bit 0 lower lane |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid while done |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data to the pads |
| mem_dq_drive | output | 1 | Pad output enable |
| mem_dq_in | input | 16 | Data from the pads |

## Verification
The bench's memory model places a fixed junk pattern on lanes that are not strobed. Reads of a single byte lane therefore show whether a design forgets to zero the disabled lane or swaps the two strobes. A swap would also corrupt the readback after a single-lane write. A monitor measures every write-enable pulse and every output-enable window, and flags a short pulse, output enable dropping during a write, or pad drive inside the turnaround after a read. A design that skips the release window shows up there, and in a read-to-done latency that is shorter than expected. Requests with both enables off, and requests raised while busy, reveal a design that lets a stray strobe through or accepts a second request mid-cycle: the memory contents or the pulse count change.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WPULSE   = 3'd1,
    ST_WHOLD    = 3'd2,
    ST_RACCESS  = 3'd3,
    ST_RRELEASE = 3'd4
  } seq_state_t;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int WR_CYC = 15,
  parameter int RD_CYC = 18,
  parameter int TA_CYC = 5,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_be_n,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             lat_en,
  output logic             cap_en,
  output logic             clr_en,
  output logic             mem_cs_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic             mem_lb_n,
  output logic             mem_ub_n,
  output logic             mem_dq_drive,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

  seq_state_t state_q, state_d;
  logic cs_d, we_d, oe_d, lb_d, ub_d, drv_d, busy_d, done_d;
  logic lb_q, ub_q;
  logic lane_lb_d, lane_ub_d;
  logic accept, empty_req;

  assign accept    = (state_q == ST_IDLE) & req_valid;
  assign empty_req = &req_be_n;

  always_comb begin
    state_d   = state_q;
    cs_d      = 1'b1;
    we_d      = 1'b1;
    oe_d      = 1'b1;
    lb_d      = 1'b1;
    ub_d      = 1'b1;
    drv_d     = 1'b0;
    busy_d    = busy;
    done_d    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    lat_en    = 1'b0;
    cap_en    = 1'b0;
    clr_en    = 1'b0;
    lane_lb_d = lb_q;
    lane_ub_d = ub_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (empty_req) begin
            done_d = 1'b1;
            busy_d = 1'b0;
            clr_en = ~req_write;
          end else begin
            lat_en    = 1'b1;
            busy_d    = 1'b1;
            tmr_load  = 1'b1;
            lane_lb_d = req_be_n[0];
            lane_ub_d = req_be_n[1];
            cs_d      = 1'b0;
            lb_d      = req_be_n[0];
            ub_d      = req_be_n[1];
            if (req_write) begin
              state_d = ST_WPULSE;
              we_d    = 1'b0;
              drv_d   = 1'b1;
              tmr_val = WR_LD;
            end else begin
              state_d = ST_RACCESS;
              oe_d    = 1'b0;
              tmr_val = RD_LD;
            end
          end
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) begin
          state_d = ST_WHOLD;
          drv_d   = 1'b1;
        end else begin
          cs_d  = 1'b0;
          we_d  = 1'b0;
          lb_d  = lb_q;
          ub_d  = ub_q;
          drv_d = 1'b1;
        end
      end
      ST_WHOLD: begin
        state_d = ST_IDLE;
        busy_d  = 1'b0;
        done_d  = 1'b1;
      end
      ST_RACCESS: begin
        if (tmr_expired) begin
          state_d  = ST_RRELEASE;
          cap_en   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TA_LD;
        end else begin
          cs_d = 1'b0;
          oe_d = 1'b0;
          lb_d = lb_q;
          ub_d = ub_q;
        end
      end
      ST_RRELEASE: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      mem_cs_n     <= 1'b1;
      mem_we_n     <= 1'b1;
      mem_oe_n     <= 1'b1;
      mem_lb_n     <= 1'b1;
      mem_ub_n     <= 1'b1;
      mem_dq_drive <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      lb_q         <= 1'b1;
      ub_q         <= 1'b1;
    end else begin
      state_q      <= state_d;
      mem_cs_n     <= cs_d;
      mem_we_n     <= we_d;
      mem_oe_n     <= oe_d;
      mem_lb_n     <= lb_d;
      mem_ub_n     <= ub_d;
      mem_dq_drive <= drv_d;
      busy         <= busy_d;
      done         <= done_d;
      lb_q         <= lane_lb_d;
      ub_q         <= lane_ub_d;
    end
  end

  // checker state: pulse length and cycles since output enable released
  logic [CNT_W-1:0] we_low_cnt;
  logic [CNT_W-1:0] oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_hi_cnt  <= CNT_W'(TA_CYC);
    end else begin
      if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
      else           we_low_cnt <= '0;
      if (!mem_oe_n)                          oe_hi_cnt <= '0;
      else if (oe_hi_cnt < CNT_W'(TA_CYC))    oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_drive));

  // R2
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_drive && !mem_cs_n));

  // R2
  we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= CNT_W'(WR_CYC)));

  // R4
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_drive));

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_drive |-> (mem_oe_n && oe_hi_cnt >= CNT_W'(TA_CYC)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/sram_lane_data.sv
module sram_lane_data #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_en,
  input  logic          cap_en,
  input  logic          clr_en,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be_n,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] rdata
);

  localparam int LANE_W = DW / 2;

  logic [1:0]    be_q;
  logic [DW-1:0] rd_mask;
  logic [DW-1:0] rdata_d;
  logic          rdata_en;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      assign rd_mask[g*LANE_W +: LANE_W] = {LANE_W{~be_q[g]}};
    end
  endgenerate

  always_comb begin
    rdata_en = cap_en | clr_en;
    rdata_d  = cap_en ? (mem_dq_in & rd_mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      be_q       <= 2'b11;
    end else if (lat_en) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
      be_q       <= req_be_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rdata_en) rdata <= rdata_d;
  end

  // R5
  mask_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_en) |-> ((rdata & ~rd_mask) == '0));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int CLK_NS   = 4,
  parameter int T_WP_NS  = 50,
  parameter int T_CW_NS  = 60,
  parameter int T_AW_NS  = 60,
  parameter int T_DW_NS  = 30,
  parameter int T_RC_NS  = 70,
  parameter int T_REL_NS = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_drive,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int WR_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                               max2(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int RD_CYC = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int TA_CYC = ns_to_cyc(T_REL_NS, CLK_NS);
  localparam int CNT_W  = $clog2(max2(max2(WR_CYC, RD_CYC), TA_CYC) + 2);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             lat_en, cap_en, clr_en;

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_lane_seq #(
    .WR_CYC (WR_CYC),
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_be_n     (req_be_n),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .lat_en       (lat_en),
    .cap_en       (cap_en),
    .clr_en       (clr_en),
    .mem_cs_n     (mem_cs_n),
    .mem_we_n     (mem_we_n),
    .mem_oe_n     (mem_oe_n),
    .mem_lb_n     (mem_lb_n),
    .mem_ub_n     (mem_ub_n),
    .mem_dq_drive (mem_dq_drive),
    .busy         (busy),
    .done         (done)
  );

  sram_lane_data #(.AW(AW), .DW(DW)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_en     (lat_en),
    .cap_en     (cap_en),
    .clr_en     (clr_en),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be_n   (req_be_n),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rdata      (rdata)
  );

  // R3
  strobe_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lb_n == 1'b0 || mem_ub_n == 1'b0) |-> !mem_cs_n);

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be_n = 2'b11;
  logic        busy, done;
  logic [15:0] rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_drive;
  logic [15:0] mem_dq_in;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be_n(req_be_n),
    .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
  );

  // memory model: 16 words, undriven lanes show a junk pattern
  logic [15:0] marr [16];
  logic        rd_on;
  assign rd_on = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = { (rd_on && !mem_ub_n) ? marr[mem_addr[3:0]][15:8] : 8'h5A,
                       (rd_on && !mem_lb_n) ? marr[mem_addr[3:0]][7:0]  : 8'hC3 };

  // monitor, sampling at negedge
  logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_lb_n = 1'b1, p_ub_n = 1'b1;
  logic [15:0] p_dq = '0;
  logic [18:0] p_addr = '0;
  logic        p_drv = 1'b0;
  int we_len = 0, oe_len = 0, drv_len = 0, oe_hi = 99;
  int we_pulses = 0, we_len_bad = 0, oe_len_bad = 0, oe_in_wr = 0, ta_bad = 0;
  int cyc = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (!mem_we_n) begin
        we_len = we_len + 1;
        if (!mem_oe_n) oe_in_wr = oe_in_wr + 1;
        if (mem_dq_drive) drv_len = drv_len + 1;
      end
      if (!mem_oe_n) oe_len = oe_len + 1;
      if (mem_dq_drive && (!mem_oe_n || oe_hi < 5)) ta_bad = ta_bad + 1;
      if (!p_we_n && mem_we_n) begin
        we_pulses = we_pulses + 1;
        if (we_len != 15 || drv_len < 8 || !mem_dq_drive) we_len_bad = we_len_bad + 1;
        if (!p_lb_n) marr[p_addr[3:0]][7:0]  = p_dq[7:0];
        if (!p_ub_n) marr[p_addr[3:0]][15:8] = p_dq[15:8];
        we_len = 0;
        drv_len = 0;
      end
      if (!p_oe_n && mem_oe_n) begin
        if (oe_len != 18) oe_len_bad = oe_len_bad + 1;
        oe_len = 0;
      end
      if (!mem_oe_n) oe_hi = 0;
      else if (oe_hi < 99) oe_hi = oe_hi + 1;
    end
    p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_lb_n = mem_lb_n; p_ub_n = mem_ub_n;
    p_dq = mem_dq_out; p_addr = mem_addr; p_drv = mem_dq_drive;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request; returns data and latency in cycles from the accepting edge
  task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] be, output logic [15:0] rd, output int lat,
                       output bit busy_ok);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_be_n = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ok = (&be) ? !busy : busy;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (!done && !busy) busy_ok = 1'b0;
    end
    rd = rdata;
    if (busy) busy_ok = 1'b0;
    @(negedge clk);
    if (done) busy_ok = 1'b0;
  endtask

  logic [15:0] rd;
  int lat;
  bit bok;

  task automatic t_reset;
    check(mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_drive
          && !busy && !done, "R1", "idle outputs",
          {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_drive, busy, done},
          8'b11111000);
  endtask

  task automatic t_write_full;
    do_op(1, 19'h3, 16'hBEEF, 2'b00, rd, lat, bok);
    check(lat == 17, "R2", "write latency", lat, 17);
    check(bok, "R7", "busy/done handshake on write", bok, 1);
    check(marr[3] == 16'hBEEF, "R2", "stored word", marr[3], 16'hBEEF);
    check(we_len_bad == 0 && oe_in_wr == 0, "R2", "pulse width / oe during write",
          we_len_bad + oe_in_wr, 0);
  endtask

  task automatic t_read_full;
    do_op(0, 19'h3, 16'h0, 2'b00, rd, lat, bok);
    check(rd == 16'hBEEF, "R4", "read word", rd, 16'hBEEF);
    check(lat == 24, "R6", "read latency incl. turnaround", lat, 24);
    check(bok, "R7", "busy/done handshake on read", bok, 1);
    check(oe_len_bad == 0, "R4", "oe window length", oe_len_bad, 0);
  endtask

  task automatic t_lanes;
    do_op(1, 19'h5, 16'h1234, 2'b00, rd, lat, bok);
    do_op(1, 19'h5, 16'hAA77, 2'b10, rd, lat, bok);
    check(marr[5] == 16'h1277, "R3", "lower-only write", marr[5], 16'h1277);
    do_op(1, 19'h5, 16'h99EE, 2'b01, rd, lat, bok);
    check(marr[5] == 16'h9977, "R3", "upper-only write", marr[5], 16'h9977);
    do_op(0, 19'h5, 16'h0, 2'b10, rd, lat, bok);
    check(rd == 16'h0077, "R5", "lower-only read masks upper", rd, 16'h0077);
    do_op(0, 19'h5, 16'h0, 2'b01, rd, lat, bok);
    check(rd == 16'h9900, "R5", "upper-only read masks lower", rd, 16'h9900);
  endtask

  task automatic t_empty;
    int pulses;
    pulses = we_pulses;
    do_op(1, 19'h3, 16'h0000, 2'b11, rd, lat, bok);
    check(lat == 1, "R8", "empty write latency", lat, 1);
    check(bok && we_pulses == pulses, "R8", "empty write no memory cycle",
          we_pulses - pulses, 0);
    do_op(0, 19'h3, 16'h0, 2'b00, rd, lat, bok);
    check(rd == 16'hBEEF, "R8", "word untouched after empty write", rd, 16'hBEEF);
    do_op(0, 19'h3, 16'h0, 2'b11, rd, lat, bok);
    check(rd == 16'h0000 && lat == 1, "R8", "empty read returns zero", rd, 0);
  endtask

  task automatic t_busy_ignore;
    int pulses;
    pulses = we_pulses;
    @(negedge clk);
    req_write = 1; req_addr = 19'h7; req_wdata = 16'h4242; req_be_n = 2'b00; req_valid = 1;
    @(negedge clk);
    req_addr = 19'h8; req_wdata = 16'hDEAD;
    repeat (4) @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(we_pulses - pulses == 1, "R7", "one write while busy", we_pulses - pulses, 1);
    check(marr[8] == 16'h0000, "R7", "request while busy ignored", marr[8], 0);
    check(marr[7] == 16'h4242, "R7", "accepted write stored", marr[7], 16'h4242);
  endtask

  task automatic t_turnaround;
    do_op(0, 19'h7, 16'h0, 2'b00, rd, lat, bok);
    do_op(1, 19'h9, 16'h5151, 2'b00, rd, lat, bok);
    check(ta_bad == 0, "R6", "drive inside release window", ta_bad, 0);
    check(marr[9] == 16'h5151, "R6", "write after read", marr[9], 16'h5151);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) marr[i] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_full();
    t_read_full();
    t_lanes();
    t_empty();
    t_busy_ignore();
    t_turnaround();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule